// File: doc/BRIEF.md
# Parallel EEPROM Page-Write Sequencer

This block sits on the host side of a byte-wide, parallel, page-programmable EEPROM. It handles one page per request. The request gives a page number, the index of the last byte to load (byte count minus one), and a completion mode. Data bytes come from a local buffer over a valid/ready stream. The block drives chip-enable, write-enable and output-enable, together with the address and data buses. Each page write starts with the three-byte unlock command. The data bytes then follow back-to-back, well inside the device's byte-load window.

After the final strobe, the device starts its internal programming on its own. The block has two ways to find the end of that programming. In fixed mode it waits a set number of cycles that covers the worst-case programming time. In poll mode it waits past the device's quiet window, then issues status reads until two reads in a row return the same value. Normal data reads are never issued during a request.

A busy flag covers the time from acceptance to completion. Requests offered while busy are not taken.

Top module: `pgw_ctrl`

## Requirements
- R1: After reset, and while idle, all three strobes are high, the data bus is not driven, busy is low and req_ready is high.
- R2: The first three write strobes of every request carry, in this order, address 0x5555 with data 0xAA, address 0x2AAA with data 0x55, and address 0x5555 with data 0xA0.
- R3: After the unlock, exactly req_last+1 write strobes follow. Strobe i carries address {req_page, i[6:0]} (page in bits 16..7) and the i-th byte accepted from the data stream.
- R4: Chip-enable and address are set at least T_SU cycles before write-enable falls. Write-enable stays low for T_PW cycles. Address and data stay constant while write-enable is low, and the bus is driven at its rising edge.
- R5: While data is available, consecutive write-strobe falling edges within one request are exactly T_SU+T_PW+T_HD cycles apart.
- R6: In fixed mode (req_poll=0), no read strobe is issued and done comes T_DONE cycles after the final byte cycle, which is after the device's programming has ended.
- R7: In poll mode (req_poll=1), no read strobe comes earlier than T_START cycles after the final byte cycle. Done is raised only after two successive status reads return equal values.
- R8: Output-enable and write-enable are never low together, and the data bus is not driven while output-enable is low.
- R9: busy is high from the cycle after acceptance until done. While busy, req_ready is low and an offered request has no effect.
- R10: done is a single-cycle pulse, after which busy is low and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Page-write request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_page | input | PAGE_W | Page number |
| req_last | input | OFS_W | Number of bytes minus one |
| req_poll | input | 1 | 1: status polling, 0: fixed wait |
| dat_valid | input | 1 | Data byte available |
| dat_ready | output | 1 | Byte taken this cycle if valid |
| dat_byte | input | DAT_W | Data byte |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_addr | output | PAGE_W+OFS_W | Device address |
| mem_dout | output | DAT_W | Write data to device |
| mem_dout_en | output | 1 | Drive enable for mem_dout |
| mem_din | input | DAT_W | Read data from device |

## Verification
A wrong slot counter shows up on the address bus within one byte cycle. It appears either as an unlock word out of order, or as a data byte landing one offset away in the device model's array. A timer or mode fault shows up when done is raised: too early in fixed mode, so the model is still programming, or as a read strobe during the device's quiet window in poll mode. A phase-counter fault changes the fall-to-fall spacing of write-enable at the next strobe, so the model flags it before the page is committed.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_LOAD, ST_WAIT, ST_POLL, ST_DONE} pgw_state_e;
  typedef enum logic [1:0] {PH_IDLE, PH_SU, PH_PW, PH_HD} pgw_phase_e;

  localparam int unsigned CMD_LEN = 3;

  // unlock word address for command slot idx
  function automatic logic [31:0] pgw_cmd_addr(input logic [1:0] idx);
    return (idx == 2'd1) ? 32'h0000_2AAA : 32'h0000_5555;
  endfunction

  // unlock word data for command slot idx
  function automatic logic [7:0] pgw_cmd_data(input logic [1:0] idx);
    case (idx)
      2'd0:    return 8'hAA;
      2'd1:    return 8'h55;
      default: return 8'hA0;
    endcase
  endfunction

  // page number in the upper field, byte offset in the lower field
  function automatic logic [31:0] pgw_data_addr(input logic [31:0] page,
                                                input logic [31:0] ofs,
                                                input int ofs_w);
    return (page << ofs_w) | ofs;
  endfunction
endpackage

// File: rtl/pgw_bus_cycle.sv
module pgw_bus_cycle #(
  parameter int AW   = 17,
  parameter int DW   = 8,
  parameter int T_SU = 2,
  parameter int T_PW = 3,
  parameter int T_HD = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          go_read,
  input  logic [AW-1:0] go_addr,
  input  logic [DW-1:0] go_data,
  output logic          free,
  output logic          fin,
  output logic          ce_n,
  output logic          we_n,
  output logic          oe_n,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] rd_data
);
  import pgw_pkg::*;

  localparam int TM1 = (T_SU > T_PW) ? T_SU : T_PW;
  localparam int TMX = (TM1 > T_HD) ? TM1 : T_HD;
  localparam int CW  = $clog2(TMX + 1);

  pgw_phase_e    ph;
  logic [CW-1:0] cnt;
  logic          rd;
  logic          last_tick;

  assign last_tick = (cnt == '0);
  assign fin       = (ph == PH_HD) && last_tick;
  assign free      = (ph == PH_IDLE) || fin;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      cnt     <= '0;
      rd      <= 1'b0;
      addr    <= '0;
      dout    <= '0;
      rd_data <= '0;
    end else if (go && free) begin
      ph   <= PH_SU;
      cnt  <= CW'(T_SU - 1);
      rd   <= go_read;
      addr <= go_addr;
      dout <= go_data;
    end else begin
      case (ph)
        PH_SU: if (last_tick) begin ph <= PH_PW; cnt <= CW'(T_PW - 1); end
               else cnt <= cnt - 1'b1;
        PH_PW: if (last_tick) begin
                 ph  <= PH_HD;
                 cnt <= CW'(T_HD - 1);
                 if (rd) rd_data <= din;
               end else cnt <= cnt - 1'b1;
        PH_HD: if (last_tick) ph <= PH_IDLE;
               else cnt <= cnt - 1'b1;
        default: ;
      endcase
    end
  end

  assign ce_n    = (ph == PH_IDLE);
  assign we_n    = !((ph == PH_PW) && !rd);
  assign oe_n    = !((ph == PH_PW) && rd);
  assign dout_en = (ph != PH_IDLE) && !rd;
endmodule

// File: rtl/pgw_wait.sv
module pgw_wait #(
  parameter int TW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] val,
  output logic          expire
);
  logic          run;
  logic [TW-1:0] cnt;

  assign expire = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (load) begin
      run <= 1'b1;
      cnt <= val;
    end else if (expire) begin
      run <= 1'b0;
    end else if (run) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/pgw_ctrl.sv
module pgw_ctrl #(
  parameter int PAGE_W  = 10,
  parameter int OFS_W   = 7,
  parameter int DAT_W   = 8,
  parameter int T_SU    = 2,
  parameter int T_PW    = 3,
  parameter int T_HD    = 2,
  parameter int T_START = 70,
  parameter int T_DONE  = 400
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [PAGE_W-1:0]       req_page,
  input  logic [OFS_W-1:0]        req_last,
  input  logic                    req_poll,
  input  logic                    dat_valid,
  output logic                    dat_ready,
  input  logic [DAT_W-1:0]        dat_byte,
  output logic                    busy,
  output logic                    done,
  output logic                    mem_ce_n,
  output logic                    mem_we_n,
  output logic                    mem_oe_n,
  output logic [PAGE_W+OFS_W-1:0] mem_addr,
  output logic [DAT_W-1:0]        mem_dout,
  output logic                    mem_dout_en,
  input  logic [DAT_W-1:0]        mem_din
);
  import pgw_pkg::*;

  localparam int AW   = PAGE_W + OFS_W;
  localparam int KW   = OFS_W + 2;
  localparam int TMAX = (T_START > T_DONE) ? T_START : T_DONE;
  localparam int TW   = $clog2(TMAX + 1);

  pgw_state_e       state;
  logic [PAGE_W-1:0] page_q;
  logic [OFS_W-1:0]  last_q;
  logic              poll_q;
  logic [KW-1:0]     k;
  logic              have_prev;
  logic [DAT_W-1:0]  prev;

  // named internal events
  logic          in_load, in_poll, cmd_slot, dat_slot, load_over;
  logic          cyc_free, cyc_fin, cyc_go, dat_take, poll_go, poll_match;
  logic          tmr_load, tmr_expire;
  logic [KW-1:0] slot_ofs;
  logic [AW-1:0] go_addr;
  logic [DAT_W-1:0] go_data, rd_data;

  assign in_load   = (state == ST_LOAD);
  assign in_poll   = (state == ST_POLL);
  assign slot_ofs  = k - KW'(CMD_LEN);
  assign cmd_slot  = in_load && (k < KW'(CMD_LEN));
  assign dat_slot  = in_load && !cmd_slot && (slot_ofs <= KW'(last_q));
  assign load_over = in_load && !cmd_slot && !dat_slot;

  assign dat_ready  = dat_slot && cyc_free;
  assign dat_take   = dat_ready && dat_valid;
  assign poll_match = in_poll && cyc_fin && have_prev && (rd_data == prev);
  assign poll_go    = in_poll && cyc_free && !poll_match;
  assign cyc_go     = (cmd_slot && cyc_free) || dat_take || poll_go;
  assign tmr_load   = load_over && cyc_free;

  always_comb begin
    if (cmd_slot) begin
      go_addr = AW'(pgw_cmd_addr(k[1:0]));
      go_data = DAT_W'(pgw_cmd_data(k[1:0]));
    end else if (in_poll) begin
      go_addr = AW'(pgw_data_addr(32'(page_q), 32'd0, OFS_W));
      go_data = '0;
    end else begin
      go_addr = AW'(pgw_data_addr(32'(page_q), 32'(slot_ofs[OFS_W-1:0]), OFS_W));
      go_data = dat_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      page_q    <= '0;
      last_q    <= '0;
      poll_q    <= 1'b0;
      k         <= '0;
      have_prev <= 1'b0;
      prev      <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          page_q    <= req_page;
          last_q    <= req_last;
          poll_q    <= req_poll;
          k         <= '0;
          have_prev <= 1'b0;
          state     <= ST_LOAD;
        end
        ST_LOAD: begin
          if (cyc_go) k <= k + 1'b1;
          if (tmr_load) state <= ST_WAIT;
        end
        ST_WAIT: if (tmr_expire) state <= poll_q ? ST_POLL : ST_DONE;
        ST_POLL: if (cyc_fin) begin
          if (poll_match) state <= ST_DONE;
          else begin
            prev      <= rd_data;
            have_prev <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_DONE);

  pgw_bus_cycle #(.AW(AW), .DW(DAT_W), .T_SU(T_SU), .T_PW(T_PW), .T_HD(T_HD)) u_cyc (
    .clk(clk), .rst_n(rst_n), .go(cyc_go), .go_read(in_poll),
    .go_addr(go_addr), .go_data(go_data), .free(cyc_free), .fin(cyc_fin),
    .ce_n(mem_ce_n), .we_n(mem_we_n), .oe_n(mem_oe_n), .addr(mem_addr),
    .dout(mem_dout), .dout_en(mem_dout_en), .din(mem_din), .rd_data(rd_data)
  );

  pgw_wait #(.TW(TW)) u_wait (
    .clk(clk), .rst_n(rst_n), .load(tmr_load),
    .val(poll_q ? TW'(T_START) : TW'(T_DONE)), .expire(tmr_expire)
  );
endmodule

// File: rtl/pgw_ctrl_chk.sv
module pgw_ctrl_chk #(
  parameter int AW = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          busy,
  input logic          done,
  input logic          mem_ce_n,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic [AW-1:0] mem_addr,
  input logic          mem_dout_en,
  input logic          in_load,
  input logic          in_poll
);
  a_r8_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  a_r8_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dout_en);

  a_r7_read_only_polling: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> in_poll);

  a_r4_we_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_dout_en));

  a_r4_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));

  a_r3_write_only_loading: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> in_load);

  a_r9_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  a_r10_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !done));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dout_en));
endmodule

bind pgw_ctrl pgw_ctrl_chk #(.AW(PAGE_W + OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .busy(busy), .done(done),
  .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
  .mem_addr(mem_addr), .mem_dout_en(mem_dout_en),
  .in_load(in_load), .in_poll(in_poll)
);

// File: tb/pgw_ctrl_tb.sv
`timescale 1ns/1ps
module pgw_ctrl_tb;
  localparam int SPAN    = 7;    // T_SU+T_PW+T_HD with defaults 2,3,2
  localparam int QUIET   = 60;   // model: quiet cycles before programming
  localparam int PROG    = 300;  // model: programming duration
  localparam int T_START = 70;
  localparam int T_DONE  = 400;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic        req_valid = 0, req_poll = 0, dat_valid = 1;
  logic [9:0]  req_page = 0;
  logic [6:0]  req_last = 0;
  logic        req_ready, dat_ready, busy, done;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dout_en;
  logic [16:0] mem_addr;
  logic [7:0]  mem_dout, dat_byte;
  logic [7:0]  mem_din = 8'h00;

  pgw_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_page(req_page), .req_last(req_last), .req_poll(req_poll),
    .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_byte(dat_byte),
    .busy(busy), .done(done), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_addr(mem_addr), .mem_dout(mem_dout),
    .mem_dout_en(mem_dout_en), .mem_din(mem_din)
  );

  int n_run = 0, n_fail = 0;
  bit reported = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    end
  endtask

  function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
    return seed ^ 8'((i * 37) + 11);
  endfunction

  // data source
  logic [7:0] cur_seed = 0;
  int  dcount = 0;
  bit  dclr = 0;
  assign dat_byte = pat(cur_seed, dcount);
  always @(posedge clk)
    if (dclr) dcount <= 0;
    else if (dat_valid && dat_ready) dcount <= dcount + 1;

  // device model
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [7:0]  arr [int];
  logic [7:0]  pbuf [128];
  bit          ploaded [128];
  logic [16:0] wlog_a [200];
  logic [7:0]  wlog_d [200];
  int  wn = 0, cmd_cnt = 0, quiet = 0, wtimer = 0, last_fall = -1000;
  int  err_tim = 0, err_space = 0, err_page = 0, err_read = 0;
  int  commits = 0, n_reads = 0, wr_end = 0, addr_age = 0;
  bit  unlock_bad = 0, pg_set = 0, writing = 0, tog = 0, prev_we = 1, prev_oe = 1;
  logic [9:0]  pg = 0;
  logic [16:0] lat_addr = 0, prev_addr = 0;

  function automatic bit cmd_ok(input int n, input logic [16:0] a, input logic [7:0] d);
    case (n)
      0: return (a == 17'h05555) && (d == 8'hAA);
      1: return (a == 17'h02AAA) && (d == 8'h55);
      default: return (a == 17'h05555) && (d == 8'hA0);
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      cmd_cnt = 0; quiet = 0; unlock_bad = 0; pg_set = 0;
      prev_we = 1; prev_oe = 1; last_fall = -1000;
      for (int i = 0; i < 128; i++) ploaded[i] = 0;
    end else begin
      addr_age = (mem_addr == prev_addr) ? addr_age + 1 : 1;
      prev_addr = mem_addr;
      if (writing) begin
        wtimer--;
        if (wtimer == 0) begin writing = 0; wr_end = cyc; end
      end
      if (prev_we && !mem_we_n) begin
        lat_addr = mem_addr;
        if (cyc - last_fall < 100 && cyc - last_fall != SPAN) err_space++;
        last_fall = cyc;
        if (mem_ce_n || addr_age < 2) err_tim++;
      end
      if (!mem_we_n && !prev_we && mem_addr != lat_addr) err_tim++;
      if (!prev_we && mem_we_n) begin
        if (!mem_dout_en || writing) err_tim++;
        wlog_a[wn] = lat_addr; wlog_d[wn] = mem_dout;
        if (wn < 199) wn++;
        if (cmd_cnt < 3) begin
          if (!cmd_ok(cmd_cnt, lat_addr, mem_dout)) unlock_bad = 1;
        end else begin
          if (!pg_set) begin pg = lat_addr[16:7]; pg_set = 1; end
          else if (lat_addr[16:7] != pg) err_page++;
          pbuf[lat_addr[6:0]] = mem_dout;
          ploaded[lat_addr[6:0]] = 1;
        end
        cmd_cnt++;
        quiet = 0;
      end else if (cmd_cnt > 0 && mem_we_n) begin
        quiet++;
        if (quiet >= QUIET) begin
          if (cmd_cnt > 3 && !unlock_bad) begin
            for (int i = 0; i < 128; i++)
              arr[int'({pg, 7'(i)})] = ploaded[i] ? pbuf[i] : 8'hFF;
            writing = 1; wtimer = PROG; commits++;
          end
          cmd_cnt = 0; unlock_bad = 0; pg_set = 0;
          for (int i = 0; i < 128; i++) ploaded[i] = 0;
        end
      end
      if (prev_oe && !mem_oe_n) begin
        n_reads++;
        if (cmd_cnt > 0 || mem_dout_en) err_read++;
        if (writing) begin tog = ~tog; mem_din <= {1'b0, tog, 6'b0}; end
        else mem_din <= arr.exists(int'(mem_addr)) ? arr[int'(mem_addr)] : 8'hFF;
      end
      prev_we = mem_we_n;
      prev_oe = mem_oe_n;
    end
  end

  // stimulus table: {page, last, poll, seed}
  localparam logic [25:0] VEC [6] = '{
    {10'd0,    7'd0,   1'b0, 8'h3C},
    {10'd1023, 7'd127, 1'b1, 8'hA5},
    {10'd5,    7'd63,  1'b0, 8'h11},
    {10'd512,  7'd1,   1'b1, 8'hF0},
    {10'd77,   7'd127, 1'b0, 8'h5A},
    {10'd300,  7'd9,   1'b1, 8'h00}
  };

  int s_tim, s_space, s_page, s_read, s_commit, s_reads;

  task automatic start_op(input logic [9:0] p, input logic [6:0] l, input bit pm,
                          input logic [7:0] sd);
    @(negedge clk);
    wn = 0; cur_seed = sd; dclr = 1;
    s_tim = err_tim; s_space = err_space; s_page = err_page; s_read = err_read;
    s_commit = commits; s_reads = n_reads;
    @(negedge clk);
    dclr = 0;
    req_page = p; req_last = l; req_poll = pm; req_valid = 1;
    chk(req_ready == 1, "R9", "ready before request", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 0;
    chk(busy == 1 && req_ready == 0, "R9", "busy after accept", int'(busy), 1);
  endtask

  task automatic finish_op(input logic [9:0] p, input logic [6:0] l, input bit pm,
                           input logic [7:0] sd);
    int n = 0, bad = 0, done_cyc;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    done_cyc = cyc;
    chk(done == 1, "R10", "done seen", int'(done), 1);
    chk(wn == int'(l) + 4, "R3", "strobe count", wn, int'(l) + 4);
    for (int i = 0; i < 3; i++)
      if (!cmd_ok(i, wlog_a[i], wlog_d[i])) bad++;
    chk(bad == 0, "R2", "unlock words wrong", bad, 0);
    bad = 0;
    for (int i = 0; i <= int'(l); i++)
      if (wlog_a[i+3] != {p, 7'(i)} || wlog_d[i+3] != pat(sd, i)) bad++;
    chk(bad == 0, "R3", "bytes on bus wrong", bad, 0);
    chk(commits == s_commit + 1, "R3", "page committed", commits - s_commit, 1);
    bad = 0;
    for (int i = 0; i < 128; i++) begin
      logic [7:0] e = (i <= int'(l)) ? pat(sd, i) : 8'hFF;
      if (!arr.exists(int'({p, 7'(i)})) || arr[int'({p, 7'(i)})] != e) bad++;
    end
    chk(bad == 0, "R3", "array contents wrong", bad, 0);
    chk(err_tim == s_tim && err_page == s_page, "R4", "timing faults",
        err_tim - s_tim + err_page - s_page, 0);
    chk(err_space == s_space, "R5", "strobe spacing faults", err_space - s_space, 0);
    if (pm) begin
      chk(!writing, "R7", "device still programming at done", int'(writing), 0);
      chk(err_read == s_read, "R7", "early or bad reads", err_read - s_read, 0);
      chk(n_reads - s_reads >= 2, "R7", "status reads", n_reads - s_reads, 2);
      chk(done_cyc - wr_end <= 4 * SPAN, "R7", "poll latency", done_cyc - wr_end, 4 * SPAN);
    end else begin
      chk(!writing, "R6", "device still programming at done", int'(writing), 0);
      chk(n_reads == s_reads, "R6", "reads in fixed mode", n_reads - s_reads, 0);
    end
    @(negedge clk);
    chk(done == 0 && busy == 0, "R10", "single pulse then idle", int'(done) + int'(busy), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dout_en, "R1", "strobes in reset",
        int'(mem_ce_n & mem_we_n & mem_oe_n), 1);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && req_ready && !done, "R1", "idle after reset", int'(busy), 0);

    for (int v = 0; v < 6; v++) begin
      start_op(VEC[v][25:16], VEC[v][15:9], VEC[v][8], VEC[v][7:0]);
      finish_op(VEC[v][25:16], VEC[v][15:9], VEC[v][8], VEC[v][7:0]);
    end

    // R9: request offered while busy is refused
    start_op(10'd9, 7'd20, 1'b0, 8'h77);
    repeat (20) @(negedge clk);
    req_page = 10'd600; req_valid = 1;
    #1;
    chk(req_ready == 0, "R9", "ready while busy", int'(req_ready), 0);
    @(negedge clk);
    req_valid = 0;
    finish_op(10'd9, 7'd20, 1'b0, 8'h77);
    begin
      int strobes = 0;
      for (int i = 0; i < 50; i++) begin
        @(negedge clk);
        if (!mem_ce_n) strobes++;
      end
      chk(strobes == 0, "R9", "refused request started later", strobes, 0);
      chk(!arr.exists(int'({10'd600, 7'd0})), "R9", "refused page written", 1, 0);
    end

    // R1: reset in the middle of loading returns to idle
    start_op(10'd44, 7'd100, 1'b1, 8'h99);
    repeat (200) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk(mem_ce_n && mem_we_n && !busy && req_ready, "R1", "idle after mid-op reset",
        int'(busy), 0);
    rst_n = 1;
    repeat (QUIET + PROG + 20) @(negedge clk);
    chk(!arr.exists(int'({10'd44, 7'd0})), "R2", "partial page committed", 1, 0);
    start_op(10'd45, 7'd3, 1'b1, 8'h42);
    finish_op(10'd45, 7'd3, 1'b1, 8'h42);

    report();
    $finish;
  end
endmodule